// File: doc/BRIEF.md
# Destination Address Receive Filter

This block sits at the head of a receive path and decides, for every incoming frame, whether the frame is kept or dropped. The decision depends only on the 48-bit destination address at the start of the frame. Software programs a station address into three 16-bit registers and sets two enable bits. One bit allows frames sent to the all-ones broadcast address. The other allows frames whose destination equals the station address exactly. The block compares the address one byte at a time as the bytes arrive, so it stores no header.

Header bytes arrive on a valid/ready stream. A beat takes place on a rising clock edge where `s_valid` and `s_ready` are both high. The block never applies back-pressure: `s_ready` stays high, and the source may insert idle cycles between bytes. A beat with `s_sof` high carries destination byte 0, which is the first byte on the wire. One cycle after the beat that carries byte 5, the block raises `dec_valid` for a single cycle, and `dec_accept` gives the verdict. Any bytes that follow byte 5 are ignored until the next start-of-frame beat.

Top module: `addr_rx_filter`

## Requirements
- R1: Destination byte 0, the first on the wire, is compared with register select 2 bits 7:0. Byte 1 is compared with select 2 bits 15:8. Bytes 2 and 3 are compared with select 1 bits 7:0 and 15:8. Bytes 4 and 5 are compared with select 0 bits 7:0 and 15:8.
- R2: A write with `cfg_sel` = 3 sets the control word. Bit 1 enables broadcast acceptance and bit 5 enables exact-match acceptance. The other bits of the control word have no effect.
- R3: A frame counts as broadcast only when all six destination bytes are 0xFF.
- R4: A frame is accepted when at least one enabled condition holds (broadcast or exact match). Otherwise it is rejected.
- R5: `dec_valid` is high for exactly one cycle, in the cycle after the beat that carries byte 5. Each frame produces one decision, and bytes after byte 5 produce none.
- R6: A start-of-frame beat restarts address collection at byte 0, even if it arrives in the middle of a header. The abandoned header produces no decision.
- R7: A configuration write affects only frames whose start-of-frame beat comes in a later cycle. A write in the same cycle as the start-of-frame beat, or during the header, leaves the current frame's verdict unchanged.
- R8: `s_ready` is always high. Only cycles with `s_valid` high count as beats, and idle cycles between bytes do not change the verdict.
- R9: After reset, all station bytes and both enables are zero and `dec_valid` is low, so the first frame is rejected, even a broadcast frame.
- R10: Beats that arrive after reset but before any start-of-frame beat produce no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0..2 station words, 3 control |
| cfg_wdata | input | 16 | Configuration write data |
| s_valid | input | 1 | Header byte valid |
| s_ready | output | 1 | Header byte ready, always high |
| s_sof | input | 1 | Beat carries destination byte 0 |
| s_data | input | 8 | Header byte |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Verdict, qualified by dec_valid |

## Verification
The bench checks the byte order used for the station address with a frame that swaps bytes 0 and 1, and with frames that differ only in the first or last byte. A design that reads the registers in the wrong order accepts the swapped frame, and a design that compares only part of the address accepts a frame that differs in the last byte. Other tests restart a frame in the middle of its header, place extra bytes and idle gaps after byte 5, and send beats before any start of frame. A design that tracks bytes wrongly then gives a spurious or missing decision. Configuration writes placed in the start-of-frame cycle and in the middle of the header show whether the design samples its configuration at the start of the frame or afterwards.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;
  localparam int unsigned OCTET_W = 8;
  typedef logic [OCTET_W-1:0] octet_t;

  typedef struct packed {
    logic en_bcast;
    logic en_exact;
  } filt_en_t;
endpackage

// File: rtl/addr_filt_cfg.sv
module addr_filt_cfg #(
  parameter int unsigned REG_W       = 16,
  parameter int unsigned NUM_SA_REGS = 3,
  parameter int unsigned SEL_W       = 2,
  parameter int unsigned BC_EN_BIT   = 1,
  parameter int unsigned EX_EN_BIT   = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [SEL_W-1:0]             cfg_sel,
  input  logic [REG_W-1:0]             cfg_wdata,
  output logic [NUM_SA_REGS*REG_W-1:0] sa_flat,
  output addr_filt_pkg::filt_en_t      en_live
);
  localparam logic [SEL_W-1:0] CTRL_SEL = SEL_W'(NUM_SA_REGS);

  for (genvar r = 0; r < NUM_SA_REGS; r++) begin : g_sa
    logic [REG_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (cfg_we && cfg_sel == SEL_W'(r)) begin
        word_q <= cfg_wdata;
      end
    end
    assign sa_flat[r*REG_W +: REG_W] = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_live <= '0;
    end else if (cfg_we && cfg_sel == CTRL_SEL) begin
      en_live.en_bcast <= cfg_wdata[BC_EN_BIT];
      en_live.en_exact <= cfg_wdata[EX_EN_BIT];
    end
  end
endmodule

// File: rtl/addr_filt_track.sv
module addr_filt_track #(
  parameter int unsigned ADDR_BYTES = 6,
  localparam int unsigned IDX_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               beat,
  input  logic                               sof,
  input  addr_filt_pkg::octet_t              data,
  input  logic [ADDR_BYTES*8-1:0]            live_sa,
  input  addr_filt_pkg::filt_en_t            en_live,
  output logic                               last_beat,
  output logic                               exact_final,
  output logic                               bcast_final,
  output addr_filt_pkg::filt_en_t            en_frame
);
  import addr_filt_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);
  localparam logic [IDX_W-1:0] DONE_IDX = IDX_W'(ADDR_BYTES);
  localparam int unsigned      RD_DEPTH = 2 ** IDX_W;

  logic [IDX_W-1:0] pos_q;
  logic             exact_run_q;
  logic             bcast_run_q;
  filt_en_t         en_q;
  octet_t           shadow_q [ADDR_BYTES];
  octet_t           shadow_rd [RD_DEPTH];

  for (genvar k = 0; k < RD_DEPTH; k++) begin : g_rd
    if (k < ADDR_BYTES) begin : g_used
      assign shadow_rd[k] = shadow_q[k];
    end else begin : g_pad
      assign shadow_rd[k] = '0;
    end
  end

  logic [IDX_W-1:0] byte_idx;
  logic             in_hdr;
  octet_t           ref_byte;
  logic             exact_hit;
  logic             bcast_hit;
  logic             exact_now;
  logic             bcast_now;

  always_comb begin
    byte_idx  = sof ? '0 : pos_q;
    in_hdr    = beat && (sof || pos_q != DONE_IDX);
    ref_byte  = sof ? live_sa[7:0] : shadow_rd[pos_q];
    exact_hit = (data == ref_byte);
    bcast_hit = &data;
    exact_now = sof ? exact_hit : (exact_run_q && exact_hit);
    bcast_now = sof ? bcast_hit : (bcast_run_q && bcast_hit);
    last_beat = in_hdr && byte_idx == LAST_IDX;
  end

  assign exact_final = exact_now;
  assign bcast_final = bcast_now;
  assign en_frame    = (beat && sof) ? en_live : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q       <= DONE_IDX;
      exact_run_q <= 1'b0;
      bcast_run_q <= 1'b0;
    end else if (in_hdr) begin
      pos_q       <= byte_idx + IDX_W'(1);
      exact_run_q <= exact_now;
      bcast_run_q <= bcast_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (beat && sof) begin
      en_q <= en_live;
    end
  end

  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_shadow
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q[k] <= '0;
      end else if (beat && sof) begin
        shadow_q[k] <= live_sa[k*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/addr_filt_decide.sv
module addr_filt_decide (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    last_beat,
  input  logic                    exact_final,
  input  logic                    bcast_final,
  input  addr_filt_pkg::filt_en_t en_frame,
  output logic                    dec_valid,
  output logic                    dec_accept
);
  logic verdict;

  always_comb begin
    verdict = (en_frame.en_bcast && bcast_final) ||
              (en_frame.en_exact && exact_final);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= last_beat;
      dec_accept <= last_beat && verdict;
    end
  end
endmodule

// File: rtl/addr_rx_filter.sv
module addr_rx_filter #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned REG_W      = 16,
  parameter int unsigned BC_EN_BIT  = 1,
  parameter int unsigned EX_EN_BIT  = 5,
  localparam int unsigned BYTES_PER_REG = REG_W / 8,
  localparam int unsigned NUM_SA_REGS   = ADDR_BYTES / BYTES_PER_REG,
  localparam int unsigned SEL_W         = $clog2(NUM_SA_REGS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic             s_sof,
  input  logic [7:0]       s_data,
  output logic             dec_valid,
  output logic             dec_accept
);
  import addr_filt_pkg::*;

  logic [NUM_SA_REGS*REG_W-1:0] sa_flat;
  logic [ADDR_BYTES*8-1:0]      live_sa;
  filt_en_t                     en_live;
  filt_en_t                     en_frame;
  logic                         beat;
  logic                         last_beat;
  logic                         exact_final;
  logic                         bcast_final;

  assign s_ready = 1'b1;
  assign beat    = s_valid && s_ready;

  addr_filt_cfg #(
    .REG_W      (REG_W),
    .NUM_SA_REGS(NUM_SA_REGS),
    .SEL_W      (SEL_W),
    .BC_EN_BIT  (BC_EN_BIT),
    .EX_EN_BIT  (EX_EN_BIT)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .sa_flat  (sa_flat),
    .en_live  (en_live)
  );

  // Byte k of the address lives in the word counted down from the top,
  // low octet first within each word.
  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_map
    assign live_sa[k*8 +: 8] =
      sa_flat[(NUM_SA_REGS - 1 - k / BYTES_PER_REG) * REG_W + (k % BYTES_PER_REG) * 8 +: 8];
  end

  addr_filt_track #(
    .ADDR_BYTES(ADDR_BYTES)
  ) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat       (beat),
    .sof        (s_sof),
    .data       (s_data),
    .live_sa    (live_sa),
    .en_live    (en_live),
    .last_beat  (last_beat),
    .exact_final(exact_final),
    .bcast_final(bcast_final),
    .en_frame   (en_frame)
  );

  addr_filt_decide u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .last_beat  (last_beat),
    .exact_final(exact_final),
    .bcast_final(bcast_final),
    .en_frame   (en_frame),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept)
  );
endmodule

// File: rtl/addr_filt_chk.sv
module addr_filt_chk #(
  parameter int unsigned ADDR_BYTES = 6
) (
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_ready,
  input logic s_sof,
  input logic dec_valid,
  input logic dec_accept,
  input logic frame_en_bc,
  input logic frame_en_ex
);
  int unsigned hdr_cnt;
  logic        chk_beat;

  assign chk_beat = s_valid && s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_cnt <= 0;
    end else if (chk_beat && s_sof) begin
      hdr_cnt <= 1;
    end else if (chk_beat && hdr_cnt != 0 && hdr_cnt < ADDR_BYTES) begin
      hdr_cnt <= hdr_cnt + 1;
    end
  end

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  assert_decide_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_beat && !s_sof && hdr_cnt == ADDR_BYTES - 1) |=> dec_valid);

  assert_full_header_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> hdr_cnt == ADDR_BYTES);

  assert_accept_qualified_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_accept);

  assert_accept_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> (frame_en_bc || frame_en_ex));

  assert_always_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready);
endmodule

bind addr_rx_filter addr_filt_chk #(.ADDR_BYTES(ADDR_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .s_valid    (s_valid),
  .s_ready    (s_ready),
  .s_sof      (s_sof),
  .dec_valid  (dec_valid),
  .dec_accept (dec_accept),
  .frame_en_bc(en_frame.en_bcast),
  .frame_en_ex(en_frame.en_exact)
);

// File: tb/addr_rx_filter_bench.sv
module addr_rx_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        s_valid = 1'b0;
  logic        s_sof = 1'b0;
  logic [7:0]  s_data = '0;
  logic        s_ready;
  logic        dec_valid;
  logic        dec_accept;

  int errors = 0;
  int checks = 0;
  int seen   = 0;

  bit    exp_q[$];
  string tag_q[$];

  logic [47:0] m_addr = '0;
  logic [15:0] m_ctrl = '0;

  always #10 clk = ~clk;

  addr_rx_filter u_addr_rx_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .s_valid(s_valid), .s_ready(s_ready),
    .s_sof(s_sof), .s_data(s_data), .dec_valid(dec_valid),
    .dec_accept(dec_accept)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: every decision is popped from the scoreboard and compared.
  always @(negedge clk) begin
    if (rst_n && dec_valid) begin
      seen++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R5/R6/R10 unexpected decision", 1, 0);
      end else begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(dec_accept == e, t, int'(dec_accept), int'(e));
      end
    end
  end

  task automatic model_write(input logic [1:0] sel, input logic [15:0] d);
    case (sel)
      2'd2: m_addr[47:32] = {d[7:0], d[15:8]};
      2'd1: m_addr[31:16] = {d[7:0], d[15:8]};
      2'd0: m_addr[15:0]  = {d[7:0], d[15:8]};
      default: m_ctrl = d;
    endcase
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [15:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    model_write(sel, d);
  endtask

  task automatic set_station(input logic [47:0] a);
    write_reg(2'd2, {a[39:32], a[47:40]});
    write_reg(2'd1, {a[23:16], a[31:24]});
    write_reg(2'd0, {a[7:0],   a[15:8]});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic send_frame(input logic [47:0] dest, input int extra, input bit gap,
                            input int wr_at, input logic [1:0] wr_sel,
                            input logic [15:0] wr_data, input string tag);
    bit bc, ex, acc;
    bc  = (dest == 48'hFFFF_FFFF_FFFF);
    ex  = (dest == m_addr);
    acc = (m_ctrl[1] && bc) || (m_ctrl[5] && ex);
    exp_q.push_back(acc);
    tag_q.push_back(tag);
    for (int i = 0; i < 6 + extra; i++) begin
      s_valid = 1'b1;
      s_sof   = (i == 0);
      s_data  = (i < 6) ? dest[47 - 8*i -: 8] : 8'(8'h40 + i);
      if (i == wr_at) begin
        cfg_we = 1'b1; cfg_sel = wr_sel; cfg_wdata = wr_data;
      end
      @(posedge clk); #1;
      if (i == wr_at) begin
        cfg_we = 1'b0;
        model_write(wr_sel, wr_data);
      end
      s_valid = 1'b0; s_sof = 1'b0;
      if (gap) idle(1);
    end
    idle(3);
    check(exp_q.size() == 0, {tag, " decision count R5"}, exp_q.size(), 0);
  endtask

  task automatic send_raw(input int n, input bit sof_first);
    for (int i = 0; i < n; i++) begin
      s_valid = 1'b1; s_sof = sof_first && (i == 0); s_data = 8'hFF;
      @(posedge clk); #1;
    end
    s_valid = 1'b0; s_sof = 1'b0;
  endtask

  localparam logic [47:0] STA = 48'h02_11_22_33_44_55;
  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check(dec_valid == 1'b0, "R9 reset dec_valid", int'(dec_valid), 0);
    check(s_ready == 1'b1, "R8 s_ready high", int'(s_ready), 1);

    send_raw(6, 1'b0);
    idle(3);
    check(seen == 0, "R10 beats without start", seen, 0);

    send_frame(BC, 0, 0, -1, 0, 0, "R9 broadcast rejected after reset");

    set_station(STA);
    write_reg(2'd3, 16'h0020);
    send_frame(STA, 0, 0, -1, 0, 0, "R1 exact match accepted");
    send_frame(48'h11_02_22_33_44_55, 0, 0, -1, 0, 0, "R1 swapped bytes 0/1 rejected");
    send_frame(48'h02_11_22_33_44_54, 0, 0, -1, 0, 0, "R1 last byte differs rejected");
    send_frame(48'h03_11_22_33_44_55, 0, 0, -1, 0, 0, "R1 first byte differs rejected");
    send_frame(BC, 0, 0, -1, 0, 0, "R2 broadcast disabled rejected");

    write_reg(2'd3, 16'h0002);
    send_frame(BC, 0, 0, -1, 0, 0, "R3 broadcast accepted");
    send_frame(48'hFFFF_FFFF_FFFE, 0, 0, -1, 0, 0, "R3 near broadcast rejected");
    send_frame(48'h7FFF_FFFF_FFFF, 0, 0, -1, 0, 0, "R3 first byte not FF rejected");
    send_frame(STA, 0, 0, -1, 0, 0, "R2 exact disabled rejected");

    write_reg(2'd3, 16'h0022);
    send_frame(BC, 0, 0, -1, 0, 0, "R4 both enabled broadcast");
    send_frame(STA, 0, 0, -1, 0, 0, "R4 both enabled exact");
    send_frame(48'h02_11_22_33_44_56, 0, 0, -1, 0, 0, "R4 no condition rejected");

    write_reg(2'd3, 16'hFFDD);
    send_frame(BC, 0, 0, -1, 0, 0, "R2 other bits broadcast");
    send_frame(STA, 0, 0, -1, 0, 0, "R2 other bits exact");

    write_reg(2'd3, 16'h0020);
    send_frame(STA, 10, 1, -1, 0, 0, "R5 trailing bytes single decision");
    send_frame(STA, 0, 1, -1, 0, 0, "R8 idle gaps exact match");

    send_raw(3, 1'b1);
    send_frame(STA, 0, 0, -1, 0, 0, "R6 restart after partial header");

    send_frame(STA, 0, 0, 2, 2'd0, 16'h9999, "R7 mid-header write ignored");
    send_frame(STA, 0, 0, -1, 0, 0, "R7 next frame sees new station");
    set_station(STA);
    send_frame(STA, 0, 0, 0, 2'd3, 16'h0000, "R7 same-cycle write ignored");
    send_frame(STA, 0, 0, -1, 0, 0, "R7 next frame sees new control");

    idle(3);
    check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule